// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block is a chained-descriptor DMA engine. Software places a table of 8-byte descriptors in memory and strobes `start` with the table's byte address. The engine then walks the table on its own. For each entry it reads two 32-bit words over a valid/ready memory port. The low word carries the control flags, the action code and the byte count. The high word carries a buffer or table address. The engine then copies data, skips the entry, or jumps to another part of the table.

Data moves between memory and a 32-bit word stream that faces the card data path. When `toCard` is high at start, the engine reads buffer words from memory and presents them on the transmit stream. When `toCard` is low, it accepts words from the receive stream and writes them to consecutive memory words. A walk ends in one of two ways. An entry that carries the stop flag ends it normally, and the engine gives a `done` pulse. A fault ends it with a `walkErr` pulse. An entry that carries the notify flag gives a `dmaIrq` pulse when that entry completes.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset the engine is idle: `busy`, `memValid`, `txValid`, `rxReady`, `done`, `dmaIrq` and `walkErr` are all low.
- R2: A transfer entry (action bits 5:4 = 2) with `toCard` high reads its buffer in ascending word order and presents each word on `txData`. Each word is held until `txReady` is high.
- R3: A transfer entry with `toCard` low writes the received words, in arrival order, to consecutive ascending word addresses starting at the entry's address word.
- R4: A no-operation entry (action 0) moves no data. The walk continues at the entry address plus 8.
- R5: A link entry (action 3) moves no data. The walk continues at the descriptor whose address is in its address word.
- R6: After completing an entry with the stop flag (bit 1) set, the engine goes idle and pulses `done` for one cycle, in the same cycle that `busy` falls.
- R7: Completing an entry with the notify flag (bit 2) set pulses `dmaIrq` once. No other entry produces this pulse.
- R8: Reading an entry whose valid flag (bit 0) is clear ends the walk with one `walkErr` pulse and no `done`. Data moved by earlier entries is kept.
- R9: A length field (bits 31:16) of zero on a transfer entry means 65536 bytes, which is 16384 words.
- R10: A transfer entry whose address or length is not a multiple of 4, or any entry with action 1, ends the walk with `walkErr` before any of its data moves.
- R11: While `memReady` is low, a pending memory request keeps its address, direction and write data.
- R12: `start` is ignored while a walk is in progress. Neither the walk's data nor its result changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `baseAddr` (ignored while busy) |
| toCard | input | 1 | Direction for the walk: 1 memory to stream, 0 stream to memory |
| baseAddr | input | AW | Byte address of the first descriptor |
| memValid | output | 1 | Memory request valid |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | AW | Memory byte address (word aligned) |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with the read handshake |
| memReady | input | 1 | Memory accepts the request this cycle |
| txValid | output | 1 | Transmit stream word valid |
| txData | output | 32 | Transmit stream word |
| txReady | input | 1 | Transmit stream accepts the word |
| rxValid | input | 1 | Receive stream word valid |
| rxData | input | 32 | Receive stream word |
| rxReady | output | 1 | Engine accepts a receive word |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse on normal end of walk |
| dmaIrq | output | 1 | One-cycle pulse on completion of a notify entry |
| walkErr | output | 1 | One-cycle pulse on a fault that ends the walk |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and a 16-bit length field. It keeps the tables small, so that one zero-length entry covers the full 16384-word count. Single-entry transfers of every length from one to eight words are swept with the handshakes either always ready or stalled on a fixed rhythm. This brings the hold behaviour of both the memory port and the stream into play on every word. Chains that mix skip, link and transfer entries, receive-direction buffers, and each fault kind are then run, and their words and event pulses are counted against tables built by the bench.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ATTR, ST_ADDR, ST_DECODE, ST_RD, ST_PUSH, ST_RXWAIT, ST_WR
  } walkState_e;

  typedef enum logic [1:0] {
    SEL_DESC_LO, SEL_DESC_HI, SEL_BUF
  } addrSel_e;

  localparam logic [1:0] ACT_NOP  = 2'd0;
  localparam logic [1:0] ACT_RSVD = 2'd1;
  localparam logic [1:0] ACT_XFER = 2'd2;
  localparam logic [1:0] ACT_LINK = 2'd3;

  localparam int DESC_BYTES = 8;
  localparam int WORD_BYTES = 4;

  typedef struct packed {
    logic     loadBase;
    logic     latchAttr;
    logic     latchAddr;
    logic     nextDesc;
    logic     followLink;
    logic     loadCount;
    logic     stepWord;
    logic     capMem;
    logic     capRx;
    addrSel_e addrSel;
  } dpCtl_t;

endpackage

// File: rtl/sg_walk_datapath.sv
module sg_walk_datapath
  import sg_walk_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] baseAddr,
  input  logic [31:0]   memRdata,
  input  logic [31:0]   rxData,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   dataReg,
  output logic          attrValid,
  output logic          attrEnd,
  output logic          attrIrq,
  output logic [1:0]    attrAct,
  output logic          misaligned,
  output logic          lastWord
);
  localparam int CW = LW - 1;
  localparam logic [CW-1:0] FULL_WORDS = CW'(1) << (LW - 2);

  logic [AW-1:0] descAddr;
  logic [AW-1:0] bufAddr;
  logic [31:0]   attrReg;
  logic [CW-1:0] wordsLeft;
  logic [LW-1:0] lenField;

  assign lenField   = attrReg[16 +: LW];
  assign attrValid  = attrReg[0];
  assign attrEnd    = attrReg[1];
  assign attrIrq    = attrReg[2];
  assign attrAct    = attrReg[5:4];
  assign misaligned = (bufAddr[1:0] != 2'b00) || (lenField[1:0] != 2'b00);
  assign lastWord   = (wordsLeft == CW'(1));

  always_comb begin
    case (ctl.addrSel)
      SEL_DESC_LO: memAddr = descAddr;
      SEL_DESC_HI: memAddr = descAddr + AW'(WORD_BYTES);
      default:     memAddr = bufAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr  <= '0;
      bufAddr   <= '0;
      attrReg   <= '0;
      wordsLeft <= '0;
      dataReg   <= '0;
    end else begin
      if (ctl.loadBase)        descAddr <= baseAddr;
      else if (ctl.followLink) descAddr <= bufAddr;
      else if (ctl.nextDesc)   descAddr <= descAddr + AW'(DESC_BYTES);

      if (ctl.latchAttr) attrReg <= memRdata;

      if (ctl.latchAddr)     bufAddr <= memRdata[AW-1:0];
      else if (ctl.stepWord) bufAddr <= bufAddr + AW'(WORD_BYTES);

      if (ctl.loadCount)
        wordsLeft <= (lenField[LW-1:2] == '0) ? FULL_WORDS : CW'(lenField[LW-1:2]);
      else if (ctl.stepWord)
        wordsLeft <= wordsLeft - CW'(1);

      if (ctl.capMem)     dataReg <= memRdata;
      else if (ctl.capRx) dataReg <= rxData;
    end
  end
endmodule

// File: rtl/sg_walk_control.sv
module sg_walk_control
  import sg_walk_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   toCard,
  input  logic   memReady,
  input  logic   txReady,
  input  logic   rxValid,
  input  logic   attrValid,
  input  logic   attrEnd,
  input  logic   attrIrq,
  input  logic [1:0] attrAct,
  input  logic   misaligned,
  input  logic   lastWord,
  output dpCtl_t ctl,
  output logic   memValid,
  output logic   memWe,
  output logic   txValid,
  output logic   rxReady,
  output logic   busy,
  output logic   done,
  output logic   dmaIrq,
  output logic   walkErr
);
  walkState_e state, stateNext;
  logic dirQ;
  logic doneNext, irqNext, errNext;
  logic complete;

  always_comb begin
    ctl       = '0;
    ctl.addrSel = SEL_BUF;
    stateNext = state;
    memValid  = 1'b0;
    memWe     = 1'b0;
    txValid   = 1'b0;
    rxReady   = 1'b0;
    doneNext  = 1'b0;
    irqNext   = 1'b0;
    errNext   = 1'b0;
    complete  = 1'b0;

    case (state)
      ST_IDLE: if (start) begin
        ctl.loadBase = 1'b1;
        stateNext    = ST_ATTR;
      end
      ST_ATTR: begin
        memValid    = 1'b1;
        ctl.addrSel = SEL_DESC_LO;
        if (memReady) begin
          ctl.latchAttr = 1'b1;
          stateNext     = ST_ADDR;
        end
      end
      ST_ADDR: begin
        memValid    = 1'b1;
        ctl.addrSel = SEL_DESC_HI;
        if (memReady) begin
          ctl.latchAddr = 1'b1;
          stateNext     = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (!attrValid || attrAct == ACT_RSVD) begin
          errNext   = 1'b1;
          stateNext = ST_IDLE;
        end else if (attrAct == ACT_XFER) begin
          if (misaligned) begin
            errNext   = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            ctl.loadCount = 1'b1;
            stateNext     = dirQ ? ST_RD : ST_RXWAIT;
          end
        end else begin
          complete = 1'b1;
        end
      end
      ST_RD: begin
        memValid = 1'b1;
        if (memReady) begin
          ctl.capMem = 1'b1;
          stateNext  = ST_PUSH;
        end
      end
      ST_PUSH: begin
        txValid = 1'b1;
        if (txReady) begin
          ctl.stepWord = 1'b1;
          if (lastWord) complete  = 1'b1;
          else          stateNext = ST_RD;
        end
      end
      ST_RXWAIT: begin
        rxReady = 1'b1;
        if (rxValid) begin
          ctl.capRx = 1'b1;
          stateNext = ST_WR;
        end
      end
      ST_WR: begin
        memValid = 1'b1;
        memWe    = 1'b1;
        if (memReady) begin
          ctl.stepWord = 1'b1;
          if (lastWord) complete  = 1'b1;
          else          stateNext = ST_RXWAIT;
        end
      end
      default: stateNext = ST_IDLE;
    endcase

    if (complete) begin
      irqNext = attrIrq;
      if (attrAct == ACT_LINK) ctl.followLink = 1'b1;
      else                     ctl.nextDesc   = 1'b1;
      if (attrEnd) begin
        doneNext  = 1'b1;
        stateNext = ST_IDLE;
      end else begin
        stateNext = ST_ATTR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dirQ    <= 1'b0;
      done    <= 1'b0;
      dmaIrq  <= 1'b0;
      walkErr <= 1'b0;
    end else begin
      state   <= stateNext;
      if (state == ST_IDLE && start) dirQ <= toCard;
      done    <= doneNext;
      dmaIrq  <= irqNext;
      walkErr <= errNext;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker
  import sg_walk_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          toCard,
  input  logic [AW-1:0] baseAddr,
  output logic          memValid,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memReady,
  output logic          txValid,
  output logic [31:0]   txData,
  input  logic          txReady,
  input  logic          rxValid,
  input  logic [31:0]   rxData,
  output logic          rxReady,
  output logic          busy,
  output logic          done,
  output logic          dmaIrq,
  output logic          walkErr
);
  dpCtl_t     ctl;
  logic [31:0] dataReg;
  logic       attrValid, attrEnd, attrIrq, misaligned, lastWord;
  logic [1:0] attrAct;

  sg_walk_datapath #(.AW(AW), .LW(LW)) dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .baseAddr(baseAddr),
    .memRdata(memRdata), .rxData(rxData), .memAddr(memAddr), .dataReg(dataReg),
    .attrValid(attrValid), .attrEnd(attrEnd), .attrIrq(attrIrq), .attrAct(attrAct),
    .misaligned(misaligned), .lastWord(lastWord)
  );

  sg_walk_control ctrl (
    .clk(clk), .rstN(rstN), .start(start), .toCard(toCard), .memReady(memReady),
    .txReady(txReady), .rxValid(rxValid), .attrValid(attrValid), .attrEnd(attrEnd),
    .attrIrq(attrIrq), .attrAct(attrAct), .misaligned(misaligned), .lastWord(lastWord),
    .ctl(ctl), .memValid(memValid), .memWe(memWe), .txValid(txValid), .rxReady(rxReady),
    .busy(busy), .done(done), .dmaIrq(dmaIrq), .walkErr(walkErr)
  );

  assign memWdata = dataReg;
  assign txData   = dataReg;
endmodule

// File: rtl/sg_desc_walker_checker.sv
module sg_desc_walker_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          memValid,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic [31:0]   memWdata,
  input logic          memReady,
  input logic          txValid,
  input logic [31:0]   txData,
  input logic          txReady,
  input logic          rxReady,
  input logic          busy,
  input logic          done,
  input logic          walkErr
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memValid && !txValid && !rxReady));

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    walkErr |-> (!busy && !done));

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWe)
                                 && (!memWe || $stable(memWdata))));

  assert_word_aligned_R10: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memAddr[1:0] == 2'b00));
endmodule

bind sg_desc_walker sg_desc_walker_checker #(.AW(AW)) walkChk (
  .clk(clk), .rstN(rstN), .memValid(memValid), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memReady(memReady), .txValid(txValid), .txData(txData),
  .txReady(txReady), .rxReady(rxReady), .busy(busy), .done(done), .walkErr(walkErr)
);

// File: tb/sg_desc_walker_test.sv
`timescale 1ns/1ps
module sg_desc_walker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        toCard = 1'b1;
  logic [31:0] baseAddr = '0;
  logic        memValid, memWe, memReady, txValid, txReady, rxValid, rxReady;
  logic [31:0] memAddr, memWdata, memRdata, txData, rxData;
  logic        busy, done, dmaIrq, walkErr;

  always #2 clk = ~clk;

  sg_desc_walker uut (
    .clk(clk), .rstN(rstN), .start(start), .toCard(toCard), .baseAddr(baseAddr),
    .memValid(memValid), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .txValid(txValid), .txData(txData),
    .txReady(txReady), .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .busy(busy), .done(done), .dmaIrq(dmaIrq), .walkErr(walkErr)
  );

  logic [31:0] descMem [0:63];
  logic [31:0] wrMem [0:255];
  logic [31:0] segA [0:7];
  int          segN [0:7];
  int          segCount;
  logic        stallOn = 1'b0;
  logic        clrMon = 1'b0;
  int cyc = 0;
  int curSeg, curOff, txTotal, txMism, wrTotal, wrStray, rxCount;
  int doneCnt, irqCnt, errCnt;
  int checks = 0;
  int errors = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h0F0F_3C3C;
  endfunction

  function automatic logic [31:0] mkAttr(input int len, input logic [1:0] act,
                                         input logic fin, input logic irq, input logic vld);
    return {len[15:0], 10'b0, act, 1'b0, irq, fin, vld};
  endfunction

  always_comb memRdata = (memAddr < 32'h100) ? descMem[memAddr[7:2]] : pat(memAddr);
  assign memReady = !stallOn || (cyc % 3 != 1);
  assign txReady  = !stallOn || (cyc % 4 != 2);
  assign rxValid  = !stallOn || (cyc % 5 != 3);
  assign rxData   = 32'h5000_0000 + rxCount;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clrMon) begin
      curSeg <= 0; curOff <= 0; txTotal <= 0; txMism <= 0; wrTotal <= 0;
      wrStray <= 0; rxCount <= 0; doneCnt <= 0; irqCnt <= 0; errCnt <= 0;
      for (int i = 0; i < 256; i++) wrMem[i] <= '0;
    end else begin
      if (txValid && txReady) begin
        txTotal <= txTotal + 1;
        if (curSeg >= segCount) txMism <= txMism + 1;
        else begin
          if (txData != pat(segA[curSeg] + 32'(4 * curOff))) txMism <= txMism + 1;
          if (curOff + 1 == segN[curSeg]) begin curSeg <= curSeg + 1; curOff <= 0; end
          else curOff <= curOff + 1;
        end
      end
      if (rxValid && rxReady) rxCount <= rxCount + 1;
      if (memValid && memReady && memWe) begin
        wrTotal <= wrTotal + 1;
        if (memAddr >= 32'h1000 && memAddr < 32'h1400) wrMem[memAddr[9:2]] <= memWdata;
        else wrStray <= wrStray + 1;
      end
      if (done)    doneCnt <= doneCnt + 1;
      if (dmaIrq)  irqCnt  <= irqCnt + 1;
      if (walkErr) errCnt  <= errCnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearTable();
    for (int i = 0; i < 64; i++) descMem[i] = '0;
    segCount = 0;
  endtask

  task automatic putDesc(input int byteAddr, input logic [31:0] attr, input logic [31:0] addr);
    descMem[byteAddr / 4]     = attr;
    descMem[byteAddr / 4 + 1] = addr;
  endtask

  task automatic addSeg(input logic [31:0] a, input int n);
    segA[segCount] = a;
    segN[segCount] = n;
    segCount++;
  endtask

  task automatic runWalk(input logic [31:0] base, input logic dir, input logic intrude);
    int waited;
    @(negedge clk); clrMon = 1'b1;
    @(negedge clk); clrMon = 1'b0;
    baseAddr = base; toCard = dir; start = 1'b1;
    @(negedge clk); start = 1'b0;
    waited = 0;
    while (busy && waited < 40000) begin
      @(negedge clk);
      waited++;
      if (intrude && waited == 6) begin baseAddr = 32'h80; toCard = ~dir; start = 1'b1; end
      else start = 1'b0;
    end
    start = 1'b0;
    if (busy) begin
      checks++; errors++;
      $display("FAIL watchdog: walk did not end actual busy expected idle");
      rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin
    int bad;
    clearTable();
    repeat (3) @(negedge clk);
    clrMon = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "memValid", int'(memValid), 0);
    chk("R1", "events", int'(done) + int'(dmaIrq) + int'(walkErr) + int'(txValid) + int'(rxReady), 0);
    rstN = 1'b1;
    clrMon = 1'b0;

    // R2/R6/R7 sweep: one to eight words, with and without stalls
    for (int s = 0; s < 2; s++) begin
      stallOn = (s == 1);
      for (int n = 1; n <= 8; n++) begin
        clearTable();
        putDesc(0, mkAttr(4 * n, 2'd2, 1'b1, 1'b1, 1'b1), 32'h2000 + 32'(n * 256));
        addSeg(32'h2000 + 32'(n * 256), n);
        runWalk(32'h0, 1'b1, 1'b0);
        chk("R2", "tx words", txTotal, n);
        chk("R2", "tx mismatches", txMism, 0);
        chk("R6", "done pulses", doneCnt, 1);
        chk("R7", "irq pulses", irqCnt, 1);
      end
    end

    // R4/R5/R7: nop, transfer with notify, link, transfer, final transfer
    stallOn = 1'b1;
    clearTable();
    putDesc(8'h00, mkAttr(0, 2'd0, 1'b0, 1'b0, 1'b1), 32'hDEAD_0000);
    putDesc(8'h08, mkAttr(12, 2'd2, 1'b0, 1'b1, 1'b1), 32'h3000);
    putDesc(8'h10, mkAttr(0, 2'd3, 1'b0, 1'b0, 1'b1), 32'h40);
    putDesc(8'h18, mkAttr(4, 2'd2, 1'b1, 1'b0, 1'b1), 32'h7000);
    putDesc(8'h40, mkAttr(8, 2'd2, 1'b0, 1'b0, 1'b1), 32'h4000);
    putDesc(8'h48, mkAttr(4, 2'd2, 1'b1, 1'b1, 1'b1), 32'h5000);
    addSeg(32'h3000, 3); addSeg(32'h4000, 2); addSeg(32'h5000, 1);
    runWalk(32'h0, 1'b1, 1'b0);
    chk("R4", "chain words", txTotal, 6);
    chk("R5", "chain mismatches after link", txMism, 0);
    chk("R7", "irq pulses in chain", irqCnt, 2);
    chk("R6", "done in chain", doneCnt, 1);

    // R12: same chain, start pulsed with another base mid-walk
    runWalk(32'h0, 1'b1, 1'b1);
    chk("R12", "words with stray start", txTotal, 6);
    chk("R12", "mismatches with stray start", txMism, 0);
    chk("R12", "err with stray start", errCnt, 0);
    chk("R12", "done with stray start", doneCnt, 1);

    // R3: receive into two buffers
    clearTable();
    putDesc(0, mkAttr(20, 2'd2, 1'b0, 1'b0, 1'b1), 32'h1000);
    putDesc(8, mkAttr(12, 2'd2, 1'b1, 1'b0, 1'b1), 32'h1100);
    runWalk(32'h0, 1'b0, 1'b0);
    bad = 0;
    for (int i = 0; i < 5; i++) if (wrMem[i] != 32'h5000_0000 + 32'(i)) bad++;
    for (int j = 0; j < 3; j++) if (wrMem[64 + j] != 32'h5000_0005 + 32'(j)) bad++;
    chk("R3", "rx words written", wrTotal, 8);
    chk("R3", "rx word mismatches", bad, 0);
    chk("R3", "writes outside buffers", wrStray, 0);
    chk("R7", "no irq without flag", irqCnt, 0);

    // R8: invalid entry after a transfer
    clearTable();
    putDesc(0, mkAttr(8, 2'd2, 1'b0, 1'b0, 1'b1), 32'h6000);
    putDesc(8, mkAttr(8, 2'd2, 1'b1, 1'b1, 1'b0), 32'h6100);
    addSeg(32'h6000, 2);
    runWalk(32'h0, 1'b1, 1'b0);
    chk("R8", "words before invalid", txTotal, 2);
    chk("R8", "err pulses", errCnt, 1);
    chk("R8", "done pulses", doneCnt, 0);
    chk("R8", "irq pulses", irqCnt, 0);

    // R10: misaligned address, misaligned length, reserved action
    for (int k = 0; k < 3; k++) begin
      clearTable();
      if (k == 0)      putDesc(0, mkAttr(8, 2'd2, 1'b1, 1'b1, 1'b1), 32'h2002);
      else if (k == 1) putDesc(0, mkAttr(6, 2'd2, 1'b1, 1'b1, 1'b1), 32'h2000);
      else             putDesc(0, mkAttr(8, 2'd1, 1'b1, 1'b1, 1'b1), 32'h2000);
      runWalk(32'h0, 1'b1, 1'b0);
      chk("R10", "words on fault", txTotal, 0);
      chk("R10", "err pulses on fault", errCnt, 1);
      chk("R10", "done on fault", doneCnt, 0);
    end

    // R4/R6/R7: lone nop with stop and notify flags
    clearTable();
    putDesc(0, mkAttr(0, 2'd0, 1'b1, 1'b1, 1'b1), 32'h0);
    runWalk(32'h0, 1'b1, 1'b0);
    chk("R4", "nop words", txTotal + wrTotal, 0);
    chk("R6", "nop done", doneCnt, 1);
    chk("R7", "nop irq", irqCnt, 1);

    // R9: zero length means 16384 words
    stallOn = 1'b0;
    clearTable();
    putDesc(0, mkAttr(0, 2'd2, 1'b1, 1'b0, 1'b1), 32'h10000);
    addSeg(32'h10000, 16384);
    runWalk(32'h0, 1'b1, 1'b0);
    chk("R9", "full-length words", txTotal, 16384);
    chk("R9", "full-length mismatches", txMism, 0);
    chk("R9", "full-length done", doneCnt, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule